// File: doc/BRIEF.md
# Two-Level Cache Refill Sequencer

This block runs the refill that follows a miss in a small first-level cache. It sits between that cache, a larger second-level cache and main memory. The caller supplies the missing word address and whether the second level holds the line. Tag lookup and replacement are handled elsewhere. The block then drives read and write strobes on each level. Each strobe stays high for the programmed access latency of that level, counted in clock cycles.

On a second-level hit, the block copies the requested first-level line upward. On a second-level miss, it first fills the whole second-level line from memory in ascending bus beats, starting at the line-aligned address. It then forwards the first-level line that contains the requested word. The amount of data forwarded is always set by the requesting level's line size.

Every beat costs the source read latency plus the destination write latency. With latencies of 200, 20 and 2 cycles for memory, second level and first level, a hit refill takes 22 cycles and a double miss takes 902 cycles. The block reports completion with a one-cycle pulse and keeps the cycle count of the last refill on an output.

Top module: `refill_seq`

## Requirements
- R1: While reset is high and in the first cycle after it, busy, done and every strobe are low and refill_cycles is 0.
- R2: A request is taken only when busy is low. Busy rises in the next cycle. While the block is idle no strobe is raised. A request presented while busy is high has no effect on strobes, addresses, data or the cycle count.
- R3: On a second-level hit, each forwarding beat holds l2_rd for lat_l2 cycles and then l1_wr for lat_l1 cycles. A hit refill takes L1_WORDS/BUS_WORDS such beats, which is 22 cycles with the default latencies (20 and 2).
- R4: On a second-level miss, L2_WORDS/BUS_WORDS beats first hold mem_rd for lat_mem cycles and then l2_wr for lat_l2 cycles each. The total with the default latencies is 4×(200+20)+(20+2) = 902 cycles.
- R5: On a miss, the final l2_wr of the fill ends before the first l2_rd of the forward. At most one of mem_rd, l2_wr, l2_rd and l1_wr is high in any cycle.
- R6: Fill beat k uses address (req_addr with its low log2(L2_WORDS) bits cleared) + k×BUS_WORDS, on both mem_addr and l2_addr. Forward beat k uses (req_addr with its low log2(L1_WORDS) bits cleared) + k×BUS_WORDS, on both l2_addr and l1_addr.
- R7: During a write phase, wr_data equals the source read data. That data is sampled in the last cycle of the beat's read phase and held unchanged throughout the write.
- R8: done is high for exactly one cycle, in the cycle after the last l1_wr cycle, and busy is low in that cycle. refill_cycles is 0 in the first busy cycle, rises by one per busy cycle, and holds the refill's total from done until the next request is taken.
- R9: The latency inputs are sampled when a request is taken, and changing them during a refill has no effect. A programmed latency of 0 behaves as 1 cycle.
- R10: A request presented in the cycle done is high is taken, and busy is high in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Refill request |
| req_addr | input | ADDR_W | Word address that missed in the first level |
| req_l2_hit | input | 1 | Second level holds the line |
| lat_l1 | input | LAT_W | First-level write latency in cycles |
| lat_l2 | input | LAT_W | Second-level access latency in cycles |
| lat_mem | input | LAT_W | Memory read latency in cycles |
| mem_rd | output | 1 | Memory read strobe |
| mem_addr | output | ADDR_W | Memory beat address |
| mem_rdata | input | BUS_WORDS×WORD_W | Memory read data |
| l2_rd | output | 1 | Second-level read strobe |
| l2_wr | output | 1 | Second-level write strobe |
| l2_addr | output | ADDR_W | Second-level beat address |
| l2_rdata | input | BUS_WORDS×WORD_W | Second-level read data |
| l1_wr | output | 1 | First-level write strobe |
| l1_addr | output | ADDR_W | First-level beat address |
| wr_data | output | BUS_WORDS×WORD_W | Write data for the active write phase |
| busy | output | 1 | Refill in progress |
| done | output | 1 | One-cycle completion pulse |
| refill_cycles | output | CYC_W | Busy cycles of the current or last refill |

## Verification
The completion pulse and the acceptance of the next request can fall in the same cycle. Busy is already low while done is high, so a request waiting at that moment must be taken. The bench provokes this by holding a new miss request in the done cycle of a hit refill. The reference model expects the done cycle to report the old total. In the next cycle it expects busy high, the counter back at zero and mem_rd raised at the new line-aligned address.

// File: rtl/rs_pkg.sv
package rs_pkg;

    typedef enum logic [1:0] {
        STG_IDLE  = 2'd0,
        STG_FILL2 = 2'd1,
        STG_FILL1 = 2'd2
    } stage_e;

    typedef enum logic {
        PH_RD = 1'b0,
        PH_WR = 1'b1
    } phase_e;

    typedef struct packed {
        logic mem_rd;
        logic l2_wr;
        logic l2_rd;
        logic l1_wr;
    } strobe_t;

    function automatic strobe_t strobes_for(stage_e s, phase_e p);
        strobe_t o;
        o        = '0;
        o.mem_rd = (s == STG_FILL2) && (p == PH_RD);
        o.l2_wr  = (s == STG_FILL2) && (p == PH_WR);
        o.l2_rd  = (s == STG_FILL1) && (p == PH_RD);
        o.l1_wr  = (s == STG_FILL1) && (p == PH_WR);
        return o;
    endfunction

    function automatic stage_e first_stage(logic l2_hit);
        return l2_hit ? STG_FILL1 : STG_FILL2;
    endfunction

endpackage

// File: rtl/rs_lat_timer.sv
module rs_lat_timer #(
    parameter int LAT_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [LAT_W-1:0] len,
    output logic             last
);
    logic [LAT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= len;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign last = (cnt_q == LAT_W'(1));
endmodule

// File: rtl/rs_addr_gen.sv
module rs_addr_gen #(
    parameter int ADDR_W    = 16,
    parameter int L1_WORDS  = 4,
    parameter int L2_WORDS  = 16,
    parameter int BUS_WORDS = 4,
    parameter int BEAT_W    = 3
) (
    input  logic [ADDR_W-1:0] req_addr,
    input  rs_pkg::stage_e    stage,
    input  logic [BEAT_W-1:0] beat,
    output logic [ADDR_W-1:0] beat_addr
);
    import rs_pkg::*;

    localparam int              BUS_OFF = $clog2(BUS_WORDS);
    localparam logic [ADDR_W-1:0] L2_MASK = ~ADDR_W'(L2_WORDS - 1);
    localparam logic [ADDR_W-1:0] L1_MASK = ~ADDR_W'(L1_WORDS - 1);

    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] step;

    always_comb begin
        if (stage == STG_FILL2)
            base = req_addr & L2_MASK;
        else
            base = req_addr & L1_MASK;
    end

    assign step      = ADDR_W'(beat) << BUS_OFF;
    assign beat_addr = base + step;
endmodule

// File: rtl/rs_beat_latch.sv
module rs_beat_latch #(
    parameter int W = 128
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cap,
    input  logic         sel_mem,
    input  logic [W-1:0] mem_data,
    input  logic [W-1:0] l2_data,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (cap)
            q <= sel_mem ? mem_data : l2_data;
    end
endmodule

// File: rtl/refill_seq.sv
module refill_seq #(
    parameter int ADDR_W    = 16,
    parameter int WORD_W    = 32,
    parameter int L1_WORDS  = 4,
    parameter int L2_WORDS  = 16,
    parameter int BUS_WORDS = 4,
    parameter int LAT_W     = 12,
    parameter int CYC_W     = 16
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        req_valid,
    input  logic [ADDR_W-1:0]           req_addr,
    input  logic                        req_l2_hit,
    input  logic [LAT_W-1:0]            lat_l1,
    input  logic [LAT_W-1:0]            lat_l2,
    input  logic [LAT_W-1:0]            lat_mem,
    output logic                        mem_rd,
    output logic [ADDR_W-1:0]           mem_addr,
    input  logic [BUS_WORDS*WORD_W-1:0] mem_rdata,
    output logic                        l2_rd,
    output logic                        l2_wr,
    output logic [ADDR_W-1:0]           l2_addr,
    input  logic [BUS_WORDS*WORD_W-1:0] l2_rdata,
    output logic                        l1_wr,
    output logic [ADDR_W-1:0]           l1_addr,
    output logic [BUS_WORDS*WORD_W-1:0] wr_data,
    output logic                        busy,
    output logic                        done,
    output logic [CYC_W-1:0]            refill_cycles
);
    import rs_pkg::*;

    localparam int BW       = BUS_WORDS * WORD_W;
    localparam int L1_BEATS = L1_WORDS / BUS_WORDS;
    localparam int L2_BEATS = L2_WORDS / BUS_WORDS;
    localparam int BEAT_W   = $clog2(L2_BEATS + 1);

    function automatic logic [LAT_W-1:0] at_least_one(input logic [LAT_W-1:0] v);
        return (v == '0) ? LAT_W'(1) : v;
    endfunction

    stage_e             stage_q;
    phase_e             phase_q;
    logic [BEAT_W-1:0]  beat_q;
    logic [ADDR_W-1:0]  addr_q;
    logic [LAT_W-1:0]   lmem_q, ll2_q, ll1_q;
    logic               done_q;
    logic [CYC_W-1:0]   cyc_q;

    logic               accept;
    logic               active;
    logic               tmr_last;
    logic               tmr_load;
    logic [LAT_W-1:0]   tmr_len;
    logic               last_beat;
    logic [LAT_W-1:0]   src_lat, dst_lat;
    logic [ADDR_W-1:0]  beat_addr;
    logic               capture;
    strobe_t            strb;

    assign accept = (stage_q == STG_IDLE) && req_valid;
    assign active = (stage_q != STG_IDLE);

    always_comb begin
        if (stage_q == STG_FILL2) begin
            src_lat   = lmem_q;
            dst_lat   = ll2_q;
            last_beat = (beat_q == BEAT_W'(L2_BEATS - 1));
        end else begin
            src_lat   = ll2_q;
            dst_lat   = ll1_q;
            last_beat = (beat_q == BEAT_W'(L1_BEATS - 1));
        end
    end

    always_comb begin
        tmr_load = 1'b0;
        tmr_len  = '0;
        if (accept) begin
            tmr_load = 1'b1;
            tmr_len  = req_l2_hit ? at_least_one(lat_l2) : at_least_one(lat_mem);
        end else if (active && tmr_last) begin
            if (phase_q == PH_RD) begin
                tmr_load = 1'b1;
                tmr_len  = dst_lat;
            end else if (!last_beat) begin
                tmr_load = 1'b1;
                tmr_len  = src_lat;
            end else if (stage_q == STG_FILL2) begin
                tmr_load = 1'b1;
                tmr_len  = ll2_q;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= STG_IDLE;
            phase_q <= PH_RD;
            beat_q  <= '0;
            addr_q  <= '0;
            lmem_q  <= LAT_W'(1);
            ll2_q   <= LAT_W'(1);
            ll1_q   <= LAT_W'(1);
            done_q  <= 1'b0;
            cyc_q   <= '0;
        end else begin
            done_q <= 1'b0;
            if (accept) begin
                stage_q <= first_stage(req_l2_hit);
                phase_q <= PH_RD;
                beat_q  <= '0;
                addr_q  <= req_addr;
                lmem_q  <= at_least_one(lat_mem);
                ll2_q   <= at_least_one(lat_l2);
                ll1_q   <= at_least_one(lat_l1);
                cyc_q   <= '0;
            end else if (active) begin
                cyc_q <= cyc_q + 1'b1;
                if (tmr_last) begin
                    if (phase_q == PH_RD) begin
                        phase_q <= PH_WR;
                    end else if (!last_beat) begin
                        beat_q  <= beat_q + 1'b1;
                        phase_q <= PH_RD;
                    end else if (stage_q == STG_FILL2) begin
                        stage_q <= STG_FILL1;
                        beat_q  <= '0;
                        phase_q <= PH_RD;
                    end else begin
                        stage_q <= STG_IDLE;
                        phase_q <= PH_RD;
                        beat_q  <= '0;
                        done_q  <= 1'b1;
                    end
                end
            end
        end
    end

    rs_lat_timer #(.LAT_W(LAT_W)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .load (tmr_load),
        .len  (tmr_len),
        .last (tmr_last)
    );

    rs_addr_gen #(
        .ADDR_W    (ADDR_W),
        .L1_WORDS  (L1_WORDS),
        .L2_WORDS  (L2_WORDS),
        .BUS_WORDS (BUS_WORDS),
        .BEAT_W    (BEAT_W)
    ) u_addr (
        .req_addr  (addr_q),
        .stage     (stage_q),
        .beat      (beat_q),
        .beat_addr (beat_addr)
    );

    assign capture = active && (phase_q == PH_RD) && tmr_last;

    rs_beat_latch #(.W(BW)) u_latch (
        .clk      (clk),
        .rst      (rst),
        .cap      (capture),
        .sel_mem  (stage_q == STG_FILL2),
        .mem_data (mem_rdata),
        .l2_data  (l2_rdata),
        .q        (wr_data)
    );

    assign strb          = strobes_for(stage_q, phase_q);
    assign mem_rd        = strb.mem_rd;
    assign l2_wr         = strb.l2_wr;
    assign l2_rd         = strb.l2_rd;
    assign l1_wr         = strb.l1_wr;
    assign mem_addr      = beat_addr;
    assign l2_addr       = beat_addr;
    assign l1_addr       = beat_addr;
    assign busy          = active;
    assign done          = done_q;
    assign refill_cycles = cyc_q;
endmodule

// File: rtl/rs_checker.sv
module rs_checker #(
    parameter int ADDR_W    = 16,
    parameter int WORD_W    = 32,
    parameter int BUS_WORDS = 4,
    parameter int CYC_W     = 16
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        req_valid,
    input logic                        busy,
    input logic                        done,
    input logic                        mem_rd,
    input logic                        l2_rd,
    input logic                        l2_wr,
    input logic                        l1_wr,
    input logic [ADDR_W-1:0]           mem_addr,
    input logic [BUS_WORDS*WORD_W-1:0] wr_data,
    input logic [CYC_W-1:0]            refill_cycles
);
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (!busy && !done && !mem_rd && !l2_rd && !l2_wr && !l1_wr && refill_cycles == '0));

    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !(mem_rd || l2_rd || l2_wr || l1_wr));

    p_accept_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> ($past(req_valid) && refill_cycles == '0));

    p_strobe_excl_r5: assert property (@(posedge clk) disable iff (rst)
        $onehot0({mem_rd, l2_rd, l2_wr, l1_wr}));

    p_fill_before_fwd_r5: assert property (@(posedge clk) disable iff (rst)
        l2_rd |=> !mem_rd);

    p_mem_align_r6: assert property (@(posedge clk) disable iff (rst)
        mem_rd |-> ((mem_addr % ADDR_W'(BUS_WORDS)) == '0));

    p_wdata_hold_r7: assert property (@(posedge clk) disable iff (rst)
        ((l2_wr || l1_wr) && $past(l2_wr || l1_wr)) |-> $stable(wr_data));

    p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_done_after_write_r8: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(l1_wr) && !busy));

    p_busy_fall_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);
endmodule

bind refill_seq rs_checker #(
    .ADDR_W    (ADDR_W),
    .WORD_W    (WORD_W),
    .BUS_WORDS (BUS_WORDS),
    .CYC_W     (CYC_W)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (req_valid),
    .busy          (busy),
    .done          (done),
    .mem_rd        (mem_rd),
    .l2_rd         (l2_rd),
    .l2_wr         (l2_wr),
    .l1_wr         (l1_wr),
    .mem_addr      (mem_addr),
    .wr_data       (wr_data),
    .refill_cycles (refill_cycles)
);

// File: tb/sim_refill_seq.sv
`timescale 1ns/1ps
module sim_refill_seq;
    localparam int ADDR_W = 16;
    localparam int WORD_W = 32;
    localparam int BW     = 4 * WORD_W;
    localparam int LAT_W  = 12;
    localparam int CYC_W  = 16;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic              req_l2_hit = 1'b0;
    logic [LAT_W-1:0]  lat_l1 = 12'd2, lat_l2 = 12'd20, lat_mem = 12'd200;
    logic              mem_rd, l2_rd, l2_wr, l1_wr, busy, done;
    logic [ADDR_W-1:0] mem_addr, l2_addr, l1_addr;
    logic [BW-1:0]     mem_rdata, l2_rdata, wr_data;
    logic [CYC_W-1:0]  refill_cycles;

    int checks = 0;
    int fails  = 0;
    int ncyc   = 0;

    always #5 clk = ~clk;

    function automatic logic [BW-1:0] pat_mem(int a);
        logic [BW-1:0] r;
        for (int i = 0; i < 4; i++) r[i*32 +: 32] = 32'hA500_0000 ^ 32'(a + i);
        return r;
    endfunction

    function automatic logic [BW-1:0] pat_l2(int a);
        logic [BW-1:0] r;
        for (int i = 0; i < 4; i++) r[i*32 +: 32] = 32'h5A00_0000 + 32'(a + i);
        return r;
    endfunction

    // behavioural second-level store driven by observed writes
    logic [BW-1:0] l2_store [64];
    bit            l2_vld   [64] = '{default: 1'b0};
    bit            mdl_vld  [64] = '{default: 1'b0};

    assign mem_rdata = pat_mem(int'(mem_addr));
    always_comb l2_rdata = l2_vld[l2_addr[7:2]] ? l2_store[l2_addr[7:2]] : pat_l2(int'(l2_addr));

    refill_seq u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .req_l2_hit(req_l2_hit), .lat_l1(lat_l1), .lat_l2(lat_l2), .lat_mem(lat_mem),
        .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .l2_rd(l2_rd), .l2_wr(l2_wr), .l2_addr(l2_addr), .l2_rdata(l2_rdata),
        .l1_wr(l1_wr), .l1_addr(l1_addr), .wr_data(wr_data),
        .busy(busy), .done(done), .refill_cycles(refill_cycles)
    );

    typedef struct {
        logic [3:0]    strb;
        logic          busy;
        logic          done;
        int            addr;
        bit            chk_data;
        logic [BW-1:0] data;
        int            cyc;
        int            kind;
    } exp_t;

    exp_t exq[$];

    function automatic exp_t mk(logic [3:0] s, logic b, logic d, int a, bit cd,
                                logic [BW-1:0] dat, int c, int k);
        exp_t e;
        e.strb = s; e.busy = b; e.done = d; e.addr = a;
        e.chk_data = cd; e.data = dat; e.cyc = c; e.kind = k;
        return e;
    endfunction

    function automatic string tag_of(int k);
        case (k)
            1: return "R4";
            2: return "R3";
            3: return "R5";
            4: return "R8";
            default: return "R2";
        endcase
    endfunction

    function automatic int nz(logic [LAT_W-1:0] v);
        return (v == '0) ? 1 : int'(v);
    endfunction

    task automatic check(bit ok, string tag, string what, logic [BW-1:0] act, logic [BW-1:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, expv, $time);
        end
    endtask

    // reference sequence for one refill, using the latencies applied at acceptance
    task automatic push_refill(int a, bit hit);
        int lm = nz(lat_mem);
        int l2 = nz(lat_l2);
        int l1 = nz(lat_l1);
        int k = 0;
        int l2b = a & ~15;
        int l1b = a & ~3;
        int fk = hit ? 2 : 3;
        logic [BW-1:0] d;
        if (exq.size() == 0) exq.push_back(mk(4'b0000, 1'b0, 1'b0, 0, 1'b0, '0, -1, 0));
        if (!hit) begin
            for (int b = 0; b < 4; b++) begin
                int ab = l2b + 4 * b;
                for (int i = 0; i < lm; i++) begin
                    exq.push_back(mk(4'b1000, 1'b1, 1'b0, ab, 1'b0, '0, k, 1)); k++;
                end
                for (int i = 0; i < l2; i++) begin
                    exq.push_back(mk(4'b0100, 1'b1, 1'b0, ab, 1'b1, pat_mem(ab), k, 1)); k++;
                end
                mdl_vld[ab >> 2] = 1'b1;
            end
        end
        d = mdl_vld[l1b >> 2] ? pat_mem(l1b) : pat_l2(l1b);
        for (int i = 0; i < l2; i++) begin
            exq.push_back(mk(4'b0010, 1'b1, 1'b0, l1b, 1'b0, '0, k, fk)); k++;
        end
        for (int i = 0; i < l1; i++) begin
            exq.push_back(mk(4'b0001, 1'b1, 1'b0, l1b, 1'b1, d, k, fk)); k++;
        end
        exq.push_back(mk(4'b0000, 1'b0, 1'b1, 0, 1'b0, '0, k, 4));
    endtask

    // per-cycle comparison against the model, sampled mid-cycle
    exp_t          e;
    logic [3:0]    obs;
    int            aobs;
    always @(negedge clk) begin
        ncyc++;
        if (ncyc > 150000) begin
            fails++; checks++;
            $display("FAIL R8 watchdog: actual %0d cycles expected completion earlier", ncyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
        if (!rst) begin
            obs = {mem_rd, l2_wr, l2_rd, l1_wr};
            if (exq.size() > 0) begin
                e = exq.pop_front();
                check(obs == e.strb && busy == e.busy && done == e.done, tag_of(e.kind),
                      "strobes/busy/done", BW'({busy, done, obs}), BW'({e.busy, e.done, e.strb}));
                if (e.strb != 4'b0000) begin
                    aobs = mem_rd ? int'(mem_addr) : (l1_wr ? int'(l1_addr) : int'(l2_addr));
                    check(aobs == e.addr, "R6", "beat address", BW'(aobs), BW'(e.addr));
                end
                if (e.chk_data)
                    check(wr_data == e.data, "R7", "write data", wr_data, e.data);
                if (e.cyc >= 0)
                    check(int'(refill_cycles) == e.cyc, "R8", "cycle count",
                          BW'(refill_cycles), BW'(e.cyc));
            end else begin
                check(obs == 4'b0000 && !busy && !done, "R2", "idle quiet",
                      BW'({busy, done, obs}), '0);
            end
            if (l2_wr) begin
                l2_store[l2_addr[7:2]] = wr_data;
                l2_vld[l2_addr[7:2]]   = 1'b1;
            end
        end
    end

    task automatic do_req(int a, bit hit);
        while (busy) begin @(posedge clk); #1; end
        push_refill(a, hit);
        req_addr = ADDR_W'(a); req_l2_hit = hit; req_valid = 1'b1;
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    task automatic wait_done();
        while (!done) begin @(posedge clk); #1; end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check(!busy && !done && refill_cycles == '0 && !mem_rd && !l2_rd && !l2_wr && !l1_wr,
              "R1", "reset state", BW'({busy, done, refill_cycles}), '0);
        @(posedge clk); #1;

        // hit with default latencies
        do_req(32'h24, 1'b1);
        wait_done();
        check(refill_cycles == 22, "R3", "hit total", BW'(refill_cycles), BW'(22));

        // double miss with default latencies
        @(posedge clk); #1;
        do_req(32'h47, 1'b0);
        wait_done();
        check(refill_cycles == 902, "R4", "miss total", BW'(refill_cycles), BW'(902));

        // hit on the freshly filled line
        @(posedge clk); #1;
        do_req(32'h44, 1'b1);
        wait_done();
        check(refill_cycles == 22, "R3", "hit after fill", BW'(refill_cycles), BW'(22));

        // latency snapshot and ignored request while busy
        @(posedge clk); #1;
        lat_mem = 12'd5; lat_l2 = 12'd3; lat_l1 = 12'd2;
        do_req(32'h8C, 1'b0);
        lat_mem = 12'd9; lat_l2 = 12'd7; lat_l1 = 12'd4;
        req_addr = 16'h30; req_l2_hit = 1'b1; req_valid = 1'b1;
        repeat (3) begin @(posedge clk); #1; end
        req_valid = 1'b0;
        wait_done();
        check(refill_cycles == 37, "R9", "snapshot total", BW'(refill_cycles), BW'(37));
        check(refill_cycles == 37, "R2", "busy request ignored", BW'(refill_cycles), BW'(37));

        // back-to-back: new request in the done cycle
        lat_mem = 12'd5; lat_l2 = 12'd3; lat_l1 = 12'd2;
        @(posedge clk); #1;
        do_req(32'h10, 1'b1);
        wait_done();
        do_req(32'hC8, 1'b0);
        check(busy == 1'b1, "R10", "accepted in done cycle", BW'(busy), BW'(1));
        wait_done();
        check(refill_cycles == 37, "R10", "back-to-back total", BW'(refill_cycles), BW'(37));

        // zero latencies act as one cycle
        @(posedge clk); #1;
        lat_mem = '0; lat_l2 = '0; lat_l1 = '0;
        do_req(32'hF3, 1'b0);
        wait_done();
        check(refill_cycles == 10, "R9", "zero latency total", BW'(refill_cycles), BW'(10));

        repeat (4) @(posedge clk);
        #1;
        check(exq.size() == 0, "R8", "model drained", BW'(exq.size()), '0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule